// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block derives three banks of clock outputs and one feedback output from a single fast source. The source is chosen from three synchronous tick strobes. In normal operation the VCO tick is used. In bypass the block uses one of two reference ticks, picked by a select input. Each strobe marks one source-clock edge relative to the block's own fabric clock, so the whole divider tree runs on one clock, with tick enables.

A shared prescaler divides the source by 2 or 4 and emits one prescaled tick per period. Every bank divider and the feedback divider advance only on that prescaled tick. Each bank has its own ratio select:

- Banks A and B divide by 2 or 4.
- Bank C divides by 4 or 6.
- The feedback divider has four ratios.

All outputs are square waves with a 50% duty cycle. An active-low stop input parks the three banks low without cutting a pulse short, and the feedback output keeps running. An active-low master input resets every counter and flags all outputs as disabled.

Top module: `multi_bank_clkdiv`

## Requirements
- R1: The prescaler divides the source by 2 when `pre_sel`=0 and by 4 when 1. Banks A and B apply a further divide by 2 when their select is 0 and by 4 when it is 1. Overall periods are 4/8 source ticks with `pre_sel`=0 and 8/16 with `pre_sel`=1.
- R2: Bank C applies a further divide by 4 when `sel_c`=0 and by 6 when 1. Overall periods are 8/12 source ticks with `pre_sel`=0 and 16/24 with `pre_sel`=1.
- R3: The feedback divider decodes `sel_fb` after the prescaler as 0→÷4, 1→÷8, 2→÷6 and 3→÷12. Overall periods are 8/16/12/24 source ticks with `pre_sel`=0 and double those with `pre_sel`=1.
- R4: Every output is high for exactly half its period, counted in source ticks, and all lines of one bank carry the same value in every cycle.
- R5: A cycle after `mr_oe_n` is sampled low, all outputs are 0 and all four enable flags are 0. A cycle after it is sampled high, all four enable flags are 1.
- R6: While `stop_n` is low, banks A, B and C settle low and stay low, and the feedback output keeps toggling. Stop and restart take effect only while a bank's undivided level is low, so no pulse is shortened and a restart begins with a full high phase.
- R7: With `pll_en`=1 the VCO tick drives the prescaler. With `pll_en`=0 the tick selected by `ref_sel` drives it: 0 selects `ref0_tick` and 1 selects `ref1_tick`. Unselected ticks have no effect.
- R8: A change of a bank or feedback select takes effect at the end of that divider's current period, never partway through it.
- R9: After reset is released, the first source tick raises every bank output and the feedback output together.
- R10: Outputs change only in the cycle after a selected source tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all registers use its rising edge |
| mr_oe_n | input | 1 | Synchronous active-low master reset; high enables outputs |
| vco_tick | input | 1 | One-cycle strobe per VCO edge |
| ref0_tick | input | 1 | One-cycle strobe per edge of reference 0 |
| ref1_tick | input | 1 | One-cycle strobe per edge of reference 1 |
| ref_sel | input | 1 | Reference choice in bypass: 0 picks reference 0, 1 picks reference 1 |
| pll_en | input | 1 | 1 uses the VCO tick; 0 bypasses to the selected reference |
| stop_n | input | 1 | Active-low stop for banks A, B and C |
| pre_sel | input | 1 | Prescaler ratio: 0 gives ÷2, 1 gives ÷4 |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| sel_fb | input | 2 | Feedback ratio code |
| out_a | output | NA | Bank A clock lines |
| out_b | output | NB | Bank B clock lines |
| out_c | output | NC | Bank C clock lines |
| out_fb | output | 1 | Feedback clock |
| oe_a | output | 1 | Bank A drive-enable flag |
| oe_b | output | 1 | Bank B drive-enable flag |
| oe_c | output | 1 | Bank C drive-enable flag |
| oe_fb | output | 1 | Feedback drive-enable flag |

## Verification
The properties assume the following about the inputs:

- Each tick input is a strobe that is synchronous to `clk` and is sampled once per rising edge.
- `mr_oe_n` is synchronous to `clk`.
- `pre_sel` changes only while reset is held, so a prescaler retune never occurs partway through a bank period.

The stimulus drives every input at the falling edge of `clk`. Tick strobes, unselected references, stop and the bank selects are drawn freshly each cycle or at random intervals. `pre_sel` is redrawn only inside a reset sequence.

// File: rtl/mbcd_pkg.sv
// Shared types and ratio decode for the multi-bank clock divider.
// Assumes half-periods fit in CW bits and full periods in CW+1 bits.
package mbcd_pkg;

    localparam int CW = 4;

    typedef enum logic [1:0] {
        KIND_AB = 2'd0,
        KIND_C  = 2'd1,
        KIND_FB = 2'd2
    } div_kind_e;

    // Half-period, in input ticks, for a divider kind and select code.
    function automatic logic [CW-1:0] half_len(div_kind_e kind, logic [1:0] code);
        logic [CW-1:0] h;
        case (kind)
            KIND_AB: h = code[0] ? CW'(2) : CW'(1);
            KIND_C:  h = code[0] ? CW'(3) : CW'(2);
            default: begin
                case (code)
                    2'd0:    h = CW'(2);
                    2'd1:    h = CW'(4);
                    2'd2:    h = CW'(3);
                    default: h = CW'(6);
                endcase
            end
        endcase
        return h;
    endfunction

endpackage

// File: rtl/tick_source.sv
// Picks the tick strobe that drives the prescaler: the VCO tick when the
// loop is enabled, otherwise the reference tick chosen by ref_sel.
// Assumes every strobe is synchronous to the fabric clock.
module tick_source (
    input  logic vco_tick,
    input  logic ref0_tick,
    input  logic ref1_tick,
    input  logic ref_sel,
    input  logic pll_en,
    output logic src_tick
);

    logic ref_tick;

    // Reference choice for bypass operation.
    always_comb ref_tick = ref_sel ? ref1_tick : ref0_tick;

    // Loop-enable choice between VCO and reference.
    always_comb src_tick = pll_en ? vco_tick : ref_tick;

endmodule

// File: rtl/ratio_divider.sv
// Even-ratio divider advancing on an input tick. The ratio code is
// reloaded only at the period boundary. Reset parks the counter at its
// wrap point, so the first tick after reset starts a period.
// TICK_OUT=1: output is a one-cycle pulse at each period start.
// TICK_OUT=0: output is a registered 50% duty level.
module ratio_divider #(
    parameter mbcd_pkg::div_kind_e KIND     = mbcd_pkg::KIND_AB,
    parameter bit                  TICK_OUT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [1:0] code,
    output logic       pulse
);

    localparam int CW = mbcd_pkg::CW;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW:0]   last_w;
    logic          at_wrap;

    // Period boundary: counter reached twice the half-period minus one.
    always_comb begin
        last_w  = {half_q, 1'b0} - (CW+1)'(1);
        at_wrap = ({1'b0, cnt_q} >= last_w);
        cnt_nxt = cnt_q + CW'(1);
    end

    // Counter and latched half-period; the ratio reloads at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            half_q <= mbcd_pkg::half_len(KIND, code);
        end else if (adv) begin
            if (at_wrap) begin
                cnt_q  <= '0;
                half_q <= mbcd_pkg::half_len(KIND, code);
            end else begin
                cnt_q  <= cnt_nxt;
            end
        end
    end

    generate
        if (TICK_OUT) begin : g_pulse
            // Period-start strobe for downstream dividers.
            assign pulse = adv & at_wrap;
        end else begin : g_level
            logic lvl_q;
            // Output is high during the first half of each period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q <= 1'b0;
                end else if (adv) begin
                    lvl_q <= at_wrap ? 1'b1 : (cnt_nxt < half_q);
                end
            end
            assign pulse = lvl_q;
        end
    endgenerate

endmodule

// File: rtl/bank_gate.sv
// Stop gating and fan-out for one output bank. The run flag follows
// stop_n only while the undivided level is low, so every pulse leaves
// at full width. Assumes the level input is registered.
module bank_gate #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             stop_n,
    input  logic             oe,
    output logic [WIDTH-1:0] lines
);

    logic run_q;
    logic gated;

    // Run flag samples stop_n only while the bank is in its low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b1;
        end else if (!level) begin
            run_q <= stop_n;
        end
    end

    // Gated level shared by every line of the bank.
    always_comb gated = level & run_q & oe;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_line
            assign lines[i] = gated;
        end
    endgenerate

endmodule

// File: rtl/multi_bank_clkdiv.sv
// Top of the multi-bank clock divider: source choice, shared prescaler,
// three gated banks and a free-running feedback divider. mr_oe_n is the
// synchronous active-low reset and also drives the enable flags.
module multi_bank_clkdiv #(
    parameter int NA = 5,
    parameter int NB = 5,
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          mr_oe_n,
    input  logic          vco_tick,
    input  logic          ref0_tick,
    input  logic          ref1_tick,
    input  logic          ref_sel,
    input  logic          pll_en,
    input  logic          stop_n,
    input  logic          pre_sel,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic [1:0]    sel_fb,
    output logic [NA-1:0] out_a,
    output logic [NB-1:0] out_b,
    output logic [NC-1:0] out_c,
    output logic          out_fb,
    output logic          oe_a,
    output logic          oe_b,
    output logic          oe_c,
    output logic          oe_fb
);

    import mbcd_pkg::*;

    logic src_tick;
    logic pre_tick;
    logic lvl_a, lvl_b, lvl_c, lvl_fb;
    logic oe_q;

    // Enable flag mirrors the master input one cycle later.
    always_ff @(posedge clk) begin
        if (!mr_oe_n) oe_q <= 1'b0;
        else          oe_q <= 1'b1;
    end

    tick_source src_i (
        .vco_tick (vco_tick),
        .ref0_tick(ref0_tick),
        .ref1_tick(ref1_tick),
        .ref_sel  (ref_sel),
        .pll_en   (pll_en),
        .src_tick (src_tick)
    );

    ratio_divider #(.KIND(KIND_AB), .TICK_OUT(1'b1)) pre_i (
        .clk(clk), .rst_n(mr_oe_n), .adv(src_tick),
        .code({1'b0, pre_sel}), .pulse(pre_tick)
    );

    ratio_divider #(.KIND(KIND_AB), .TICK_OUT(1'b0)) div_a_i (
        .clk(clk), .rst_n(mr_oe_n), .adv(pre_tick),
        .code({1'b0, sel_a}), .pulse(lvl_a)
    );

    ratio_divider #(.KIND(KIND_AB), .TICK_OUT(1'b0)) div_b_i (
        .clk(clk), .rst_n(mr_oe_n), .adv(pre_tick),
        .code({1'b0, sel_b}), .pulse(lvl_b)
    );

    ratio_divider #(.KIND(KIND_C), .TICK_OUT(1'b0)) div_c_i (
        .clk(clk), .rst_n(mr_oe_n), .adv(pre_tick),
        .code({1'b0, sel_c}), .pulse(lvl_c)
    );

    ratio_divider #(.KIND(KIND_FB), .TICK_OUT(1'b0)) div_fb_i (
        .clk(clk), .rst_n(mr_oe_n), .adv(pre_tick),
        .code(sel_fb), .pulse(lvl_fb)
    );

    bank_gate #(.WIDTH(NA)) gate_a_i (
        .clk(clk), .rst_n(mr_oe_n), .level(lvl_a),
        .stop_n(stop_n), .oe(oe_q), .lines(out_a)
    );

    bank_gate #(.WIDTH(NB)) gate_b_i (
        .clk(clk), .rst_n(mr_oe_n), .level(lvl_b),
        .stop_n(stop_n), .oe(oe_q), .lines(out_b)
    );

    bank_gate #(.WIDTH(NC)) gate_c_i (
        .clk(clk), .rst_n(mr_oe_n), .level(lvl_c),
        .stop_n(stop_n), .oe(oe_q), .lines(out_c)
    );

    // Feedback output ignores stop.
    always_comb out_fb = lvl_fb & oe_q;

    always_comb begin
        oe_a  = oe_q;
        oe_b  = oe_q;
        oe_c  = oe_q;
        oe_fb = oe_q;
    end

endmodule

// File: rtl/multi_bank_clkdiv_chk.sv
// Port-level properties for multi_bank_clkdiv, bound to every instance.
// Assumes all inputs are synchronous to clk.
module multi_bank_clkdiv_chk #(
    parameter int NA = 5,
    parameter int NB = 5,
    parameter int NC = 4
) (
    input logic          clk,
    input logic          mr_oe_n,
    input logic          vco_tick,
    input logic          ref0_tick,
    input logic          ref1_tick,
    input logic          ref_sel,
    input logic          pll_en,
    input logic          stop_n,
    input logic [NA-1:0] out_a,
    input logic [NB-1:0] out_b,
    input logic [NC-1:0] out_c,
    input logic          out_fb,
    input logic          oe_a,
    input logic          oe_b,
    input logic          oe_c,
    input logic          oe_fb
);

    // R4
    bank_uniform_chk: assert property (@(posedge clk) disable iff (!mr_oe_n)
        (out_a == {NA{out_a[0]}}) && (out_b == {NB{out_b[0]}}) && (out_c == {NC{out_c[0]}}));

    // R5
    reset_quiet_chk: assert property (@(posedge clk)
        !mr_oe_n |=> (out_a == '0 && out_b == '0 && out_c == '0 && !out_fb
                      && !oe_a && !oe_b && !oe_c && !oe_fb));

    // R5
    enable_flag_chk: assert property (@(posedge clk)
        mr_oe_n |=> (oe_a && oe_b && oe_c && oe_fb));

    // R6
    stop_no_restart_chk: assert property (@(posedge clk) disable iff (!mr_oe_n)
        ($rose(out_a[0]) || $rose(out_b[0]) || $rose(out_c[0])) |-> $past(stop_n));

    // R10
    tick_only_chk: assert property (@(posedge clk) disable iff (!mr_oe_n)
        (!$stable(out_fb) || !$stable(out_a[0]) || !$stable(out_c[0]))
        |-> $past(pll_en ? vco_tick : (ref_sel ? ref1_tick : ref0_tick)));

endmodule

bind multi_bank_clkdiv multi_bank_clkdiv_chk #(.NA(NA), .NB(NB), .NC(NC)) chk_i (
    .clk(clk), .mr_oe_n(mr_oe_n), .vco_tick(vco_tick), .ref0_tick(ref0_tick),
    .ref1_tick(ref1_tick), .ref_sel(ref_sel), .pll_en(pll_en), .stop_n(stop_n),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_fb(out_fb),
    .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c), .oe_fb(oe_fb)
);

// File: tb/multi_bank_clkdiv_tb_top.sv
module multi_bank_clkdiv_tb_top;

    logic       clk = 1'b0;
    logic       mr_oe_n = 1'b0;
    logic       vco_tick = 1'b0, ref0_tick = 1'b0, ref1_tick = 1'b0;
    logic       ref_sel = 1'b0, pll_en = 1'b1, stop_n = 1'b1, pre_sel = 1'b0;
    logic       sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic [1:0] sel_fb = 2'd0;
    logic [4:0] out_a, out_b;
    logic [3:0] out_c;
    logic       out_fb, oe_a, oe_b, oe_c, oe_fb;

    int checks = 0;
    int fails  = 0;

    // Model state: index 0..3 = bank A, B, C, feedback.
    int  ep[4];
    int  et[4];
    bit  lvl[4];
    bit  run[3];
    bit  started;

    always #4 clk = ~clk;

    multi_bank_clkdiv dut_i (
        .clk(clk), .mr_oe_n(mr_oe_n), .vco_tick(vco_tick), .ref0_tick(ref0_tick),
        .ref1_tick(ref1_tick), .ref_sel(ref_sel), .pll_en(pll_en), .stop_n(stop_n),
        .pre_sel(pre_sel), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_fb(out_fb),
        .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c), .oe_fb(oe_fb)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Full period in source ticks from the ratio tables of R1, R2 and R3.
    function automatic int period(int idx);
        int p;
        p = pre_sel ? 4 : 2;
        case (idx)
            0: return p * (sel_a ? 4 : 2);
            1: return p * (sel_b ? 4 : 2);
            2: return p * (sel_c ? 6 : 4);
            default: begin
                case (sel_fb)
                    2'd0: return p * 4;
                    2'd1: return p * 8;
                    2'd2: return p * 6;
                    default: return p * 12;
                endcase
            end
        endcase
    endfunction

    function automatic int fan(bit v, int w);
        return v ? ((1 << w) - 1) : 0;
    endfunction

    // One clock: apply strobes, advance the model to the next edge, check.
    task automatic step(bit vt, bit t0, bit t1);
        bit src;
        vco_tick = vt; ref0_tick = t0; ref1_tick = t1;
        src = pll_en ? vt : (ref_sel ? t1 : t0);
        for (int b = 0; b < 3; b++) if (!lvl[b]) run[b] = stop_n;
        if (src) begin
            for (int d = 0; d < 4; d++) begin
                if (!started || ep[d] == et[d] - 1) begin
                    ep[d] = 0;
                    et[d] = period(d);
                end else begin
                    ep[d]++;
                end
                lvl[d] = (ep[d] < et[d] / 2);
            end
            started = 1'b1;
        end
        @(negedge clk);
        chk("R1", int'(out_a), fan(lvl[0] & run[0], 5));
        chk("R1", int'(out_b), fan(lvl[1] & run[1], 5));
        chk("R2", int'(out_c), fan(lvl[2] & run[2], 4));
        chk("R3", int'(out_fb), int'(lvl[3]));
    endtask

    task automatic do_reset();
        mr_oe_n = 1'b0;
        vco_tick = 1'b0; ref0_tick = 1'b0; ref1_tick = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5", int'({out_a, out_b, out_c, out_fb}), 0);
        chk("R5", int'({oe_a, oe_b, oe_c, oe_fb}), 0);
        started = 1'b0;
        for (int d = 0; d < 4; d++) begin ep[d] = 0; et[d] = 1; lvl[d] = 1'b0; end
        for (int b = 0; b < 3; b++) run[b] = 1'b1;
        mr_oe_n = 1'b1;
    endtask

    task automatic random_run(int n, int mode);
        pre_sel = 1'($urandom);
        sel_a = 1'($urandom); sel_b = 1'($urandom); sel_c = 1'($urandom);
        sel_fb = 2'($urandom);
        pll_en = (mode == 0);
        ref_sel = (mode == 2);
        stop_n = 1'b1;
        do_reset();
        step(1'b0, 1'b0, 1'b0);
        chk("R5", int'({oe_a, oe_b, oe_c, oe_fb}), 15);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 16 == 0) sel_a = ~sel_a;
            if ($urandom % 16 == 0) sel_b = ~sel_b;
            if ($urandom % 16 == 0) sel_c = ~sel_c;
            if ($urandom % 16 == 0) sel_fb = 2'($urandom);
            if ($urandom % 32 == 0) stop_n = ~stop_n;
            step(1'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);

        // R9: first tick after reset raises every output together.
        pre_sel = 0; sel_a = 1; sel_b = 0; sel_c = 1; sel_fb = 2'd3;
        pll_en = 1; stop_n = 1;
        do_reset();
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R9", int'({out_a[0], out_b[0], out_c[0], out_fb}), 15);
        chk("R4", int'(out_a), 31);

        // R10: no selected tick, other inputs moving, outputs hold.
        for (int i = 0; i < 10; i++) begin
            sel_a = 1'($urandom); sel_fb = 2'($urandom);
            step(1'b0, 1'($urandom), 1'($urandom));
            chk("R10", int'({out_a[0], out_b[0], out_c[0], out_fb}), 15);
        end

        // R8: bank A at 4 ticks/period; switch to 8 after tick 2.
        pre_sel = 0; sel_a = 0; sel_fb = 0;
        do_reset();
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        sel_a = 1;
        step(1'b1, 1'b0, 1'b0);
        chk("R8", int'(out_a[0]), 0);
        step(1'b1, 1'b0, 1'b0);
        chk("R8", int'(out_a[0]), 1);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R8", int'(out_a[0]), 1);
        step(1'b1, 1'b0, 1'b0);
        chk("R8", int'(out_a[0]), 0);

        // R6: stop parks banks while feedback keeps toggling.
        begin
            int fb_edges = 0;
            bit prev_fb;
            pre_sel = 0; sel_a = 0; sel_b = 1; sel_c = 1; sel_fb = 0;
            do_reset();
            for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
            stop_n = 0;
            prev_fb = out_fb;
            for (int i = 0; i < 40; i++) begin
                step(1'b1, 1'b0, 1'b0);
                if (out_fb != prev_fb) fb_edges++;
                prev_fb = out_fb;
            end
            chk("R6", int'({out_a, out_b, out_c}), 0);
            chk("R6", fb_edges, 10);
            stop_n = 1;
            for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0);
        end

        // R7: bypass on reference 1 with the VCO strobing constantly.
        begin
            int rises = 0;
            bit prev_fb = 1'b0;
            pre_sel = 0; sel_fb = 0; pll_en = 0; ref_sel = 1;
            do_reset();
            for (int i = 0; i < 96; i++) begin
                step(1'b1, 1'b1, 1'b1);
                step(1'b1, 1'b1, 1'b0);
                if (out_fb && !prev_fb) rises++;
                prev_fb = out_fb;
            end
            chk("R7", rises, 12);
        end

        // Random runs over every source mode.
        for (int r = 0; r < 36; r++) random_run(300, r % 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule